// File: doc/BRIEF.md
# E3 Serial Transmit Payload Timing Generator

This block paces a bit-serial transmit payload port of an E3 framer. One bit position of an outbound 4296-bit frame passes per rising edge of the transmit input clock. The frame holds 537 bytes: two framing-alignment bytes, five further overhead bytes, and 530 payload bytes. The block keeps the bit position and decides whether each position is overhead or payload. It raises a frame strobe at position 0. It passes payload bits from the terminal equipment on to the downstream frame assembler, together with their index inside the frame.

The overhead indicator works one clock ahead. It is high in every clock whose following position is overhead. A terminal source that sees it high repeats its current bit for one more clock. Its stream therefore stalls for exactly the overhead positions and loses no bit. The block is used in the mode where the nibble interface is off and the timing reference is the transmit input clock. The framer fills the overhead byte content, so the serial input is ignored at overhead positions.

A five-state machine controls the block. ST_HOLD is the reset state. ST_PRIME is the single clock after reset release, which raises the indicator ahead of position 0. ST_ALIGN, ST_OVHD and ST_PAYLOAD mark the class of the current position. Transitions: ST_HOLD goes to ST_PRIME. Every other state goes to the state of the class decoded for the next position: ST_ALIGN for frame bytes 0 and 1, ST_OVHD for the five other overhead bytes, ST_PAYLOAD otherwise. Reset returns every state to ST_HOLD.

Top module: `e3_tx_payload_timer`

## Requirements
- R1: A clock edge with `rst` high makes `frame_strobe`, `oh_ind`, `pl_valid` and `pl_data` 0 and `bit_pos` 0 in the following cycle. The first cycle after release is a priming cycle: `oh_ind` is 1, `frame_strobe` and `pl_valid` are 0, and `bit_pos` is 0.
- R2: From the cycle after the priming cycle, `bit_pos` starts at 0, rises by one per clock, and wraps from 4295 to 0.
- R3: `frame_strobe` is 1 exactly in the cycles where `bit_pos` is 0 after priming, once every 4296 clocks.
- R4: `oh_ind` is 1 in a cycle exactly when the position of the next cycle is an overhead position.
- R5: Positions 0 to 15 are overhead: the first alignment byte, bit 7 down to bit 0, then the second alignment byte in the same order. `oh_ind` is therefore 1 for 16 consecutive clocks, from the clock before position 0 through position 14.
- R6: Byte indices 90, 179, 268, 357 and 446 (bit positions 8b to 8b+7) are also overhead. Every other position is payload, which gives 4240 payload positions per frame.
- R7: `pl_valid` is 1 only at payload positions. While it is 1, `pl_data` equals `ser_in`; otherwise `pl_data` is 0, whatever `ser_in` carries.
- R8: `pl_index` is 0 at the first payload position of a frame (position 16) and rises by one per payload bit. Indices 4238 and 4239 fall at positions 4294 and 4295.
- R9: A source that repeats its bit for one more clock after every clock with `oh_ind` high has every bit delivered on `pl_data`, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit input clock, one bit position per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload bit from the terminal equipment |
| frame_strobe | output | 1 | High at bit position 0 of each frame |
| oh_ind | output | 1 | High when the next bit position is overhead |
| pl_valid | output | 1 | High when the current position is payload |
| pl_data | output | 1 | Payload bit to the frame assembler, 0 when not valid |
| pl_index | output | 13 | Payload bit index within the frame |
| bit_pos | output | 13 | Current bit position within the frame |

## Verification
The assertions take for granted that reset is high at the first clock edge and that `ser_in` always has a known value. They assume nothing about the pattern on `ser_in`; the pass-through and gating properties hold for any bit. The stimulus applies reset at the start and once mid-run, and changes `ser_in` only on falling edges. It models a terminal that follows the one-clock stall rule and drives the complement of its held bit in every stalled clock, so a leak of overhead-time data would show. Three bit patterns are used: all ones, alternating, and pseudo-random.

// File: rtl/e3tp_pkg.sv
`timescale 1ns/1ps
package e3tp_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PRIME,
        ST_ALIGN,
        ST_OVHD,
        ST_PAYLOAD
    } tp_state_e;

    typedef enum logic [1:0] {
        POS_ALIGN,
        POS_OVHD,
        POS_PAYLOAD
    } pos_class_e;

    // Byte index of the n-th (1-based) overhead byte that follows the alignment bytes.
    function automatic int unsigned ovhd_byte_index(int unsigned slot,
                                                    int unsigned align_bytes,
                                                    int unsigned stride);
        return (align_bytes - 1) + slot * stride;
    endfunction

endpackage

// File: rtl/e3tp_bit_counter.sv
`timescale 1ns/1ps
module e3tp_bit_counter #(
    parameter int unsigned FRAME_BITS = 4296,
    parameter int unsigned CW         = 13,
    parameter int unsigned BW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] cnt_q,
    output logic [BW-1:0] look_byte
);

    logic [CW-1:0] cnt_nx;

    always_comb begin
        if (cnt_q == CW'(FRAME_BITS - 1)) begin
            cnt_nx = '0;
        end else begin
            cnt_nx = cnt_q + 1'b1;
        end
    end

    // Byte of the position that the next cycle will present.
    assign look_byte = adv ? cnt_nx[CW-1:3] : cnt_q[CW-1:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/e3tp_pos_decoder.sv
`timescale 1ns/1ps
module e3tp_pos_decoder
    import e3tp_pkg::*;
#(
    parameter int unsigned BW             = 10,
    parameter int unsigned ALIGN_BYTES    = 2,
    parameter int unsigned EXTRA_OH_BYTES = 5,
    parameter int unsigned OH_STRIDE      = 89
) (
    input  logic [BW-1:0] byte_idx,
    output pos_class_e    cls
);

    logic [EXTRA_OH_BYTES-1:0] slot_hit;

    for (genvar s = 0; s < EXTRA_OH_BYTES; s++) begin : g_slot
        localparam int unsigned AT = ovhd_byte_index(s + 1, ALIGN_BYTES, OH_STRIDE);
        assign slot_hit[s] = (byte_idx == BW'(AT));
    end

    always_comb begin
        if (byte_idx < BW'(ALIGN_BYTES)) begin
            cls = POS_ALIGN;
        end else if (|slot_hit) begin
            cls = POS_OVHD;
        end else begin
            cls = POS_PAYLOAD;
        end
    end

endmodule

// File: rtl/e3tp_payload_index.sv
`timescale 1ns/1ps
module e3tp_payload_index #(
    parameter int unsigned PL_BITS = 4240,
    parameter int unsigned IW      = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          inc,
    output logic [IW-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (inc) begin
            if (idx_q == IW'(PL_BITS - 1)) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/e3_tx_payload_timer.sv
`timescale 1ns/1ps
module e3_tx_payload_timer
    import e3tp_pkg::*;
#(
    parameter int unsigned PAYLOAD_BYTES  = 530,
    parameter int unsigned ALIGN_BYTES    = 2,
    parameter int unsigned EXTRA_OH_BYTES = 5,
    parameter int unsigned OH_STRIDE      = 89
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_in,
    output logic        frame_strobe,
    output logic        oh_ind,
    output logic        pl_valid,
    output logic        pl_data,
    output logic [12:0] pl_index,
    output logic [12:0] bit_pos
);

    localparam int unsigned FRAME_BYTES = PAYLOAD_BYTES + ALIGN_BYTES + EXTRA_OH_BYTES;
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;
    localparam int unsigned PL_BITS     = PAYLOAD_BYTES * 8;
    localparam int unsigned CW          = $clog2(FRAME_BITS);
    localparam int unsigned IW          = $clog2(PL_BITS);
    localparam int unsigned BW          = CW - 3;

    tp_state_e     state_q, state_d;
    pos_class_e    look_cls;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] look_byte;
    logic [IW-1:0] idx_q;
    logic          adv;

    assign adv = (state_q == ST_ALIGN) || (state_q == ST_OVHD) || (state_q == ST_PAYLOAD);

    e3tp_bit_counter #(
        .FRAME_BITS(FRAME_BITS),
        .CW        (CW),
        .BW        (BW)
    ) bitcnt_i (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .cnt_q    (cnt_q),
        .look_byte(look_byte)
    );

    e3tp_pos_decoder #(
        .BW            (BW),
        .ALIGN_BYTES   (ALIGN_BYTES),
        .EXTRA_OH_BYTES(EXTRA_OH_BYTES),
        .OH_STRIDE     (OH_STRIDE)
    ) lookdec_i (
        .byte_idx(look_byte),
        .cls     (look_cls)
    );

    e3tp_payload_index #(
        .PL_BITS(PL_BITS),
        .IW     (IW)
    ) plidx_i (
        .clk  (clk),
        .rst  (rst),
        .clear(state_q == ST_ALIGN),
        .inc  (state_q == ST_PAYLOAD),
        .idx_q(idx_q)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: the class of the position the next cycle presents.
    always_comb begin
        state_d = ST_HOLD;
        unique case (state_q)
            ST_HOLD: state_d = ST_PRIME;
            ST_PRIME, ST_ALIGN, ST_OVHD, ST_PAYLOAD: begin
                unique case (look_cls)
                    POS_ALIGN: state_d = ST_ALIGN;
                    POS_OVHD:  state_d = ST_OVHD;
                    default:   state_d = ST_PAYLOAD;
                endcase
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs.
    always_comb begin
        frame_strobe = 1'b0;
        oh_ind       = 1'b0;
        pl_valid     = 1'b0;
        pl_data      = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
            end
            ST_PRIME: begin
                oh_ind = (look_cls != POS_PAYLOAD);
            end
            ST_ALIGN: begin
                frame_strobe = (cnt_q == '0);
                oh_ind       = (look_cls != POS_PAYLOAD);
            end
            ST_OVHD: begin
                oh_ind = (look_cls != POS_PAYLOAD);
            end
            ST_PAYLOAD: begin
                oh_ind   = (look_cls != POS_PAYLOAD);
                pl_valid = 1'b1;
                pl_data  = ser_in;
            end
            default: begin
            end
        endcase
    end

    assign bit_pos  = cnt_q;
    assign pl_index = idx_q;

endmodule

// File: rtl/e3tp_checker.sv
`timescale 1ns/1ps
module e3tp_checker #(
    parameter int unsigned FRAME_BITS = 4296,
    parameter int unsigned PL_BITS    = 4240,
    parameter int unsigned CW         = 13,
    parameter int unsigned IW         = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          ser_in,
    input logic          frame_strobe,
    input logic          oh_ind,
    input logic          pl_valid,
    input logic          pl_data,
    input logic [IW-1:0] pl_index,
    input logic [CW-1:0] bit_pos
);

    logic started;

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
        end else if (oh_ind) begin
            started <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!oh_ind && !frame_strobe && !pl_valid && !pl_data && bit_pos == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (started && bit_pos != CW'(FRAME_BITS - 1)) |=> (bit_pos == $past(bit_pos) + CW'(1)));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (started && bit_pos == CW'(FRAME_BITS - 1)) |=> (bit_pos == '0 && frame_strobe));

    assert_strobe_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> (bit_pos == '0 && !pl_valid && oh_ind));

    assert_lead_R4: assert property (@(posedge clk) disable iff (rst)
        oh_ind |=> !pl_valid);

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (started && !oh_ind) |=> pl_valid);

    assert_align_run_R5: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> (oh_ind && !pl_valid));

    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !pl_valid |-> !pl_data);

    assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
        pl_valid |-> (pl_data == ser_in));

    assert_last_index_R8: assert property (@(posedge clk) disable iff (rst)
        (pl_valid && bit_pos == CW'(FRAME_BITS - 1)) |-> (pl_index == IW'(PL_BITS - 1)));

endmodule

bind e3_tx_payload_timer e3tp_checker #(
    .FRAME_BITS(FRAME_BITS),
    .PL_BITS   (PL_BITS),
    .CW        (CW),
    .IW        (IW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ser_in      (ser_in),
    .frame_strobe(frame_strobe),
    .oh_ind      (oh_ind),
    .pl_valid    (pl_valid),
    .pl_data     (pl_data),
    .pl_index    (pl_index),
    .bit_pos     (bit_pos)
);

// File: tb/e3_tx_payload_timer_tb_top.sv
`timescale 1ns/1ps
module e3_tx_payload_timer_tb_top;

    localparam int N   = 4296;
    localparam int PLB = 4240;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 1'b0;
    logic        frame_strobe, oh_ind, pl_valid, pl_data;
    logic [12:0] pl_index, bit_pos;

    always #5 clk = ~clk;

    e3_tx_payload_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .frame_strobe(frame_strobe),
        .oh_ind      (oh_ind),
        .pl_valid    (pl_valid),
        .pl_data     (pl_data),
        .pl_index    (pl_index),
        .bit_pos     (bit_pos)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_oh(input int p);
        int b;
        b = p / 8;
        return (b < 2) || (b == 90) || (b == 179) || (b == 268) || (b == 357) || (b == 446);
    endfunction

    typedef struct {
        bit b;
        int idx;
    } item_t;
    item_t sb_q[$];

    // Reset value seen by the design at the last rising edge.
    logic rst_edge = 1'b1;
    always @(posedge clk) rst_edge = rst;

    // Terminal-equipment driver.
    bit          armed = 1'b0;
    bit          prev_oh = 1'b0;
    bit          cur_bit = 1'b0;
    int          k = 0;
    int          mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic step(input bit r);
        bit nb;
        @(negedge clk);
        rst = r;
        if (rst_edge) begin
            armed   = 1'b0;
            prev_oh = 1'b0;
            k       = 0;
            ser_in  = 1'b0;
        end else begin
            if (armed && !prev_oh) begin
                if (mode == 0)      nb = 1'b1;
                else if (mode == 1) nb = k[0];
                else                nb = lfsr[0];
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sb_q.push_back('{b: nb, idx: k % PLB});
                cur_bit = nb;
                ser_in  = nb;
                k++;
            end else begin
                ser_in = ~cur_bit;
            end
            armed   = armed | oh_ind;
            prev_oh = oh_ind;
        end
    endtask

    // Monitor and scoreboard.
    int n = 0;
    int exp_pos;
    int pl_cnt = 0;
    bit full = 1'b0;
    item_t it;

    always @(negedge clk) begin
        #2;
        if (!done) begin
            if (rst_edge) begin
                chk(frame_strobe == 1'b0, "R1", "frame_strobe in reset", int'(frame_strobe), 0);
                chk(oh_ind == 1'b0, "R1", "oh_ind in reset", int'(oh_ind), 0);
                chk(pl_valid == 1'b0, "R1", "pl_valid in reset", int'(pl_valid), 0);
                chk(pl_data == 1'b0, "R1", "pl_data in reset", int'(pl_data), 0);
                chk(bit_pos == 13'd0, "R1", "bit_pos in reset", int'(bit_pos), 0);
                n = 0;
                pl_cnt = 0;
                full = 1'b0;
            end else if (n == 0) begin
                chk(oh_ind == 1'b1, "R1", "oh_ind priming", int'(oh_ind), 1);
                chk(frame_strobe == 1'b0, "R1", "frame_strobe priming", int'(frame_strobe), 0);
                chk(pl_valid == 1'b0, "R1", "pl_valid priming", int'(pl_valid), 0);
                chk(bit_pos == 13'd0, "R1", "bit_pos priming", int'(bit_pos), 0);
                n = 1;
            end else begin
                exp_pos = (n - 1) % N;
                chk(int'(bit_pos) == exp_pos, "R2", "bit_pos", int'(bit_pos), exp_pos);
                chk(frame_strobe == (exp_pos == 0), "R3", "frame_strobe", int'(frame_strobe),
                    int'(exp_pos == 0));
                if (exp_pos < 15 || exp_pos == N - 1)
                    chk(oh_ind == 1'b1, "R5", "oh_ind alignment run", int'(oh_ind), 1);
                else
                    chk(oh_ind == is_oh((exp_pos + 1) % N), "R4", "oh_ind lead", int'(oh_ind),
                        int'(is_oh((exp_pos + 1) % N)));
                chk(pl_valid == !is_oh(exp_pos), "R6", "pl_valid position class", int'(pl_valid),
                    int'(!is_oh(exp_pos)));
                if (exp_pos == 0) begin
                    if (full)
                        chk(pl_cnt == PLB, "R6", "payload bits per frame", pl_cnt, PLB);
                    full = 1'b1;
                    pl_cnt = 0;
                end
                if (pl_valid) begin
                    pl_cnt++;
                    if (exp_pos == 16)
                        chk(pl_index == 13'd0, "R8", "first payload index", int'(pl_index), 0);
                    if (exp_pos == N - 2)
                        chk(pl_index == 13'd4238, "R8", "index at 4294", int'(pl_index), 4238);
                    if (exp_pos == N - 1)
                        chk(pl_index == 13'd4239, "R8", "index at 4295", int'(pl_index), 4239);
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R9", "payload with no source bit", 1, 0);
                    end else begin
                        it = sb_q.pop_front();
                        chk(pl_data == it.b, "R9", "payload bit order", int'(pl_data), int'(it.b));
                        chk(int'(pl_index) == it.idx, "R8", "pl_index", int'(pl_index), it.idx);
                    end
                end else begin
                    chk(pl_data == 1'b0, "R7", "pl_data gated", int'(pl_data), 0);
                end
                n++;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        mode = 0;
        repeat (3) step(1'b1);
        repeat (5000) step(1'b0);
        mode = 1;
        repeat (4500) step(1'b0);
        repeat (2) step(1'b1);
        mode = 2;
        repeat (9000) step(1'b0);
        step(1'b1);
        @(negedge clk);
        #5;
        chk(sb_q.size() == 0, "R9", "unconsumed source bits", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule